// File: doc/BRIEF.md
# Interconnect Performance Monitor

This block counts activity inside a coherent interconnect. It holds five 32-bit counters. Counter 0 counts clock cycles. Counters 1 to 4 each count one event that software picks. An event is named by an 8-bit identifier. The top three bits pick one of eight source ports and the low five bits pick an event code on that port. The interconnect delivers events on a flat pulse vector, one bit per port and code pair. Each counter raises its own overflow interrupt when it wraps. The integration may OR these interrupts together.

Software reaches the block through a plain memory-mapped register bus. There is no back-pressure. Every write takes effect at the clock edge where `bus_wr` is high. Every read returns its data on `bus_rdata` in the cycle after `bus_rd` is high. Page 0 (addresses 0x0000 to 0x0FFF) holds the global registers. Counter k owns the 4 KB page that starts at 0x1000*(k+1).

Top module: `ic_perf_mon`

## Requirements
- R1: After reset, every counter value, counter enable, event select and overflow flag is 0, the global enable is 0 and `irq_o` is all zeros.
- R2: Global register map. Address 0x100 holds the global enable in bit 0, and bits 15:11 read as 4, the number of event counters. Address 0xFE8 reports the revision (value 1) in bits 7:4. Read data appears on `bus_rdata` one cycle after `bus_rd`.
- R3: Counter 0 increments by exactly one on every clock edge where the global enable and its own enable are both set. Its event select always reads 0 and ignores writes.
- R4: Counter pages use four registers: offset 0x0 is the event select (bits 7:0), 0x4 is the count value, 0x8 is control (bit 0 enables the counter) and 0xC is overflow status (bit 0). An event counter with select value S increments by one on an edge where `ev_pulse_i[S]` is high. S is read as port S[7:5] and code S[4:0], so the pulse bit is port*32+code.
- R5: Only valid event codes are counted. Ports 0 to 4 accept codes 0x00 to 0x14. Ports 5 to 7 accept codes 0x00 to 0x11. A counter selecting any other code never increments.
- R6: A counter does not change while the global enable is clear or its own enable is clear, unless a bus write targets its value register.
- R7: A bus write to a counter value register wins over an increment in the same cycle; the written value is stored.
- R8: A counter increments from 0xFFFFFFFF to 0. The overflow flag is set on the edge where the counter wraps, and `irq_o[k]` is high while flag k is set.
- R9: Writing 1 to overflow status bit 0 clears the flag and writing 0 leaves it unchanged. If a wrap happens in the same cycle as a clear, the flag stays set.
- R10: Bits 15:11 at address 0x100 are read-only; a write leaves them at 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 16 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| ev_pulse_i | input | 256 | Event pulses, bit port*32+code |
| irq_o | output | 5 | Overflow interrupt, one per counter |

## Verification
The assertions take for granted that all inputs have known values once reset is released. They also take for granted that counter values move only through an increment or a value-register write, so they follow each counter against its own value in the previous cycle and against the value write strobe. The stimulus drives every input from time zero. It makes at most one bus access per cycle and changes inputs only on falling edges. Event pulses last one cycle, so the expected counts are whole numbers of pulses that can be counted directly.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int PAGE_SHIFT = 12;
  localparam logic [11:0] OFF_EVSEL = 12'h000;
  localparam logic [11:0] OFF_VALUE = 12'h004;
  localparam logic [11:0] OFF_CTRL  = 12'h008;
  localparam logic [11:0] OFF_OVF   = 12'h00C;
  localparam logic [11:0] OFF_GCTL  = 12'h100;
  localparam logic [11:0] OFF_ID    = 12'hFE8;
  localparam int NCNT_LSB = 11;
  localparam int NCNT_W   = 5;
  localparam int REV_LSB  = 4;
  localparam int REV_W    = 4;

  typedef struct packed {
    logic evsel;
    logic value;
    logic ctrl;
    logic ovf;
  } ctr_we_t;
endpackage

// File: rtl/pmu_evt_pick.sv
module pmu_evt_pick #(
  parameter int NUM_PORT = 8,
  parameter int CODE_W   = 5,
  parameter int NUM_SLV  = 5,
  parameter int SLV_MAX  = 20,
  parameter int MST_MAX  = 17,
  localparam int PORT_W  = $clog2(NUM_PORT),
  localparam int EVT_W   = PORT_W + CODE_W,
  localparam int EV_BITS = NUM_PORT << CODE_W
) (
  input  logic [EVT_W-1:0]   evsel,
  input  logic [EV_BITS-1:0] ev_pulse,
  output logic               hit
);
  logic [PORT_W-1:0] port;
  logic [CODE_W-1:0] code;
  logic              code_ok;

  assign port = evsel[EVT_W-1:CODE_W];
  assign code = evsel[CODE_W-1:0];

  always_comb begin
    if (port < PORT_W'(NUM_SLV)) code_ok = (code <= CODE_W'(SLV_MAX));
    else                         code_ok = (code <= CODE_W'(MST_MAX));
  end

  assign hit = code_ok & ev_pulse[evsel];
endmodule

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int CNT_W   = 32,
  parameter int EVT_W   = 8,
  parameter bit HAS_SEL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pmu_pkg::ctr_we_t we,
  input  logic [CNT_W-1:0] wdata,
  input  logic             gen_en,
  input  logic             hit,
  output logic [EVT_W-1:0] evsel,
  output logic [CNT_W-1:0] cnt,
  output logic             en,
  output logic             ovf
);
  logic inc;
  logic wrap;

  assign inc  = gen_en & en & hit;
  assign wrap = inc & ~we.value & (&cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      en  <= 1'b0;
      ovf <= 1'b0;
    end else begin
      if (we.value)   cnt <= wdata;
      else if (inc)   cnt <= cnt + 1'b1;
      if (we.ctrl)    en  <= wdata[0];
      if (wrap)       ovf <= 1'b1;
      else if (we.ovf && wdata[0]) ovf <= 1'b0;
    end
  end

  if (HAS_SEL) begin : g_sel
    always_ff @(posedge clk) begin
      if (!rst_n)        evsel <= '0;
      else if (we.evsel) evsel <= wdata[EVT_W-1:0];
    end
  end else begin : g_nosel
    logic unused_sel;
    assign unused_sel = we.evsel;
    assign evsel = '0;
  end
endmodule

// File: rtl/pmu_regif.sv
module pmu_regif
  import pmu_pkg::*;
#(
  parameter int NUM_CTR = 5,
  parameter int CNT_W   = 32,
  parameter int EVT_W   = 8,
  parameter int ADDR_W  = 16,
  parameter int REV     = 1,
  localparam int PG_W   = ADDR_W - PAGE_SHIFT
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            bus_wr,
  input  logic                            bus_rd,
  input  logic [ADDR_W-1:0]               bus_addr,
  input  logic                            gen_en,
  input  logic [NUM_CTR-1:0][EVT_W-1:0]   evsel,
  input  logic [NUM_CTR-1:0][CNT_W-1:0]   cnt,
  input  logic [NUM_CTR-1:0]              en,
  input  logic [NUM_CTR-1:0]              ovf,
  output logic                            gctl_we,
  output ctr_we_t                         we [NUM_CTR],
  output logic [CNT_W-1:0]                rdata
);
  logic [PG_W-1:0]  pg;
  logic [11:0]      off;
  logic [CNT_W-1:0] rd_next;

  assign pg  = bus_addr[ADDR_W-1:PAGE_SHIFT];
  assign off = bus_addr[PAGE_SHIFT-1:0];

  always_comb begin
    gctl_we = bus_wr && (pg == '0) && (off == OFF_GCTL);
    for (int k = 0; k < NUM_CTR; k++) begin
      we[k].evsel = bus_wr && (pg == PG_W'(k + 1)) && (off == OFF_EVSEL);
      we[k].value = bus_wr && (pg == PG_W'(k + 1)) && (off == OFF_VALUE);
      we[k].ctrl  = bus_wr && (pg == PG_W'(k + 1)) && (off == OFF_CTRL);
      we[k].ovf   = bus_wr && (pg == PG_W'(k + 1)) && (off == OFF_OVF);
    end
  end

  always_comb begin
    rd_next = '0;
    if (pg == '0) begin
      if (off == OFF_GCTL) begin
        rd_next[0] = gen_en;
        rd_next[NCNT_LSB +: NCNT_W] = NCNT_W'(NUM_CTR - 1);
      end else if (off == OFF_ID) begin
        rd_next[REV_LSB +: REV_W] = REV_W'(REV);
      end
    end
    for (int k = 0; k < NUM_CTR; k++) begin
      if (pg == PG_W'(k + 1)) begin
        case (off)
          OFF_EVSEL: rd_next[EVT_W-1:0] = evsel[k];
          OFF_VALUE: rd_next = cnt[k];
          OFF_CTRL:  rd_next[0] = en[k];
          OFF_OVF:   rd_next[0] = ovf[k];
          default:   rd_next = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      rdata <= '0;
    else if (bus_rd) rdata <= rd_next;
    else             rdata <= '0;
  end
endmodule

// File: rtl/ic_perf_mon.sv
module ic_perf_mon
  import pmu_pkg::*;
#(
  parameter int NUM_CTR  = 5,
  parameter int CNT_W    = 32,
  parameter int ADDR_W   = 16,
  parameter int NUM_PORT = 8,
  parameter int CODE_W   = 5,
  parameter int NUM_SLV  = 5,
  parameter int SLV_MAX  = 20,
  parameter int MST_MAX  = 17,
  parameter int REV      = 1,
  localparam int EVT_W   = $clog2(NUM_PORT) + CODE_W,
  localparam int EV_BITS = NUM_PORT << CODE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [CNT_W-1:0]   bus_wdata,
  output logic [CNT_W-1:0]   bus_rdata,
  input  logic [EV_BITS-1:0] ev_pulse_i,
  output logic [NUM_CTR-1:0] irq_o
);
  logic                          gen_en_q;
  logic                          gctl_we;
  ctr_we_t                       we [NUM_CTR];
  logic [NUM_CTR-1:0]            val_we;
  logic [NUM_CTR-1:0][EVT_W-1:0] evsel_vec;
  logic [NUM_CTR-1:0][CNT_W-1:0] cnt_vec;
  logic [NUM_CTR-1:0]            en_vec;
  logic [NUM_CTR-1:0]            ovf_vec;

  always_ff @(posedge clk) begin
    if (!rst_n)       gen_en_q <= 1'b0;
    else if (gctl_we) gen_en_q <= bus_wdata[0];
  end

  pmu_regif #(
    .NUM_CTR(NUM_CTR), .CNT_W(CNT_W), .EVT_W(EVT_W),
    .ADDR_W(ADDR_W), .REV(REV)
  ) u_regif (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .gen_en(gen_en_q), .evsel(evsel_vec), .cnt(cnt_vec),
    .en(en_vec), .ovf(ovf_vec),
    .gctl_we(gctl_we), .we(we), .rdata(bus_rdata)
  );

  for (genvar k = 0; k < NUM_CTR; k++) begin : g_ctr
    logic hit;
    assign val_we[k] = we[k].value;

    if (k == 0) begin : g_cyc
      assign hit = 1'b1;
    end else begin : g_evt
      pmu_evt_pick #(
        .NUM_PORT(NUM_PORT), .CODE_W(CODE_W), .NUM_SLV(NUM_SLV),
        .SLV_MAX(SLV_MAX), .MST_MAX(MST_MAX)
      ) u_pick (
        .evsel(evsel_vec[k]), .ev_pulse(ev_pulse_i), .hit(hit)
      );
    end

    pmu_counter #(
      .CNT_W(CNT_W), .EVT_W(EVT_W), .HAS_SEL(k != 0)
    ) u_cnt (
      .clk(clk), .rst_n(rst_n), .we(we[k]), .wdata(bus_wdata),
      .gen_en(gen_en_q), .hit(hit),
      .evsel(evsel_vec[k]), .cnt(cnt_vec[k]),
      .en(en_vec[k]), .ovf(ovf_vec[k])
    );
  end

  assign irq_o = ovf_vec;
endmodule

// File: rtl/pmu_checker.sv
module pmu_checker #(
  parameter int NUM_CTR = 5,
  parameter int CNT_W   = 32
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          gen_en,
  input logic [NUM_CTR-1:0]            en,
  input logic [NUM_CTR-1:0][CNT_W-1:0] cnt,
  input logic [NUM_CTR-1:0]            ovf,
  input logic [NUM_CTR-1:0]            val_we
);
  AST_CYCLE_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_en && en[0] && !val_we[0]) |=> (cnt[0] == CNT_W'($past(cnt[0]) + 1'b1))); // R3

  for (genvar k = 0; k < NUM_CTR; k++) begin : g_chk
    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      !val_we[k] |=> (cnt[k] == $past(cnt[k]) || cnt[k] == CNT_W'($past(cnt[k]) + 1'b1))); // R4

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      ((!gen_en || !en[k]) && !val_we[k]) |=> $stable(cnt[k])); // R6

    AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      ((&cnt[k]) && !val_we[k]) |=> (cnt[k] != '0 || ovf[k])); // R8

    AST_FLAG_ONLY_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf[k]) |-> (cnt[k] == '0)); // R8
  end
endmodule

bind ic_perf_mon pmu_checker #(.NUM_CTR(NUM_CTR), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .gen_en(gen_en_q), .en(en_vec),
  .cnt(cnt_vec), .ovf(ovf_vec), .val_we(val_we)
);

// File: tb/sim_ic_perf_mon.sv
module sim_ic_perf_mon;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_wr = 1'b0;
  logic         bus_rd = 1'b0;
  logic [15:0]  bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic [255:0] ev = '0;
  logic [4:0]   irq_o;
  int checks = 0;
  int errors = 0;
  logic [31:0] rv;

  always #10 clk = ~clk;

  ic_perf_mon u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ev_pulse_i(ev), .irq_o(irq_o)
  );

  // evsel, pulse bit, expected count after three pulses
  localparam logic [47:0] VEC [0:7] = '{
    {8'h03, 8'h03, 32'd3},   // R4 port 0 code 3
    {8'h14, 8'h14, 32'd3},   // R5 slave upper limit
    {8'h15, 8'h15, 32'd0},   // R5 slave beyond limit
    {8'hB1, 8'hB1, 32'd3},   // R5 master upper limit
    {8'hB2, 8'hB2, 32'd0},   // R5 master beyond limit
    {8'h83, 8'h63, 32'd0},   // R4 pulse on another port
    {8'hE0, 8'hE0, 32'd3},   // R4 port 7 code 0
    {8'h9F, 8'h9F, 32'd0}    // R5 slave code 0x1F
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse(input logic [7:0] idx);
    ev[idx] = 1'b1;
    @(negedge clk);
    ev[idx] = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", {27'd0, irq_o}, 32'd0);
    rd(16'h2004, rv); chk("R1 counter1 value", rv, 32'd0);
    rd(16'h1004, rv); chk("R1 cycle value", rv, 32'd0);
    rd(16'h3008, rv); chk("R1 counter2 enable", rv, 32'd0);
    // R2 global map
    rd(16'h0100, rv); chk("R2 global ctrl", rv, 32'h0000_2000);
    rd(16'h0FE8, rv); chk("R2 revision", rv, 32'h0000_0010);
    // R10 read-only field
    wr(16'h0100, 32'hFFFF_FFFF);
    rd(16'h0100, rv); chk("R10 count field", rv, 32'h0000_2001);

    // table walk on counter 1
    wr(16'h2008, 32'd1);
    for (int i = 0; i < 8; i++) begin
      wr(16'h2000, {24'd0, VEC[i][47:40]});
      wr(16'h2004, 32'd0);
      for (int p = 0; p < 3; p++) pulse(VEC[i][39:32]);
      rd(16'h2004, rv);
      chk($sformatf("R4/R5 vector %0d", i), rv, VEC[i][31:0]);
    end

    // R3 cycle counter: enabled at one edge, disabled 11 edges later
    wr(16'h1000, 32'hFF);
    rd(16'h1000, rv); chk("R3 cycle evsel reads 0", rv, 32'd0);
    wr(16'h1008, 32'd1);
    repeat (10) @(negedge clk);
    wr(16'h1008, 32'd0);
    rd(16'h1004, rv); chk("R3 cycle count", rv, 32'd11);

    // R6 counter enable off
    wr(16'h2000, 32'h03);
    wr(16'h2004, 32'd0);
    wr(16'h2008, 32'd0);
    pulse(8'h03);
    rd(16'h2004, rv); chk("R6 counter enable off", rv, 32'd0);
    // R6 global enable off
    wr(16'h2008, 32'd1);
    wr(16'h0100, 32'd0);
    pulse(8'h03);
    rd(16'h2004, rv); chk("R6 global enable off", rv, 32'd0);
    wr(16'h0100, 32'd1);

    // R7 write beats increment
    ev[3] = 1'b1;
    wr(16'h2004, 32'h55);
    ev[3] = 1'b0;
    rd(16'h2004, rv); chk("R7 write priority", rv, 32'h55);

    // R8 wrap on counter 2
    wr(16'h3000, 32'h01);
    wr(16'h3004, 32'hFFFF_FFFE);
    wr(16'h3008, 32'd1);
    pulse(8'h01);
    chk("R8 no irq before wrap", {27'd0, irq_o}, 32'd0);
    rd(16'h3004, rv); chk("R8 all ones", rv, 32'hFFFF_FFFF);
    ev[1] = 1'b1;
    @(negedge clk);
    ev[1] = 1'b0;
    chk("R8 irq on wrap", {27'd0, irq_o}, 32'h4);
    rd(16'h3004, rv); chk("R8 wrapped to zero", rv, 32'd0);
    rd(16'h300C, rv); chk("R8 overflow flag", rv, 32'd1);

    // R9 clear semantics
    wr(16'h300C, 32'd0);
    rd(16'h300C, rv); chk("R9 write 0 keeps flag", rv, 32'd1);
    wr(16'h300C, 32'd1);
    rd(16'h300C, rv); chk("R9 write 1 clears flag", rv, 32'd0);
    chk("R9 irq low", {27'd0, irq_o}, 32'd0);
    wr(16'h3004, 32'hFFFF_FFFF);
    ev[1] = 1'b1;
    wr(16'h300C, 32'd1);
    ev[1] = 1'b0;
    rd(16'h300C, rv); chk("R9 wrap beats clear", rv, 32'd1);
    chk("R9 irq stays", {27'd0, irq_o}, 32'h4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule